// File: doc/BRIEF.md
# Programmable External Bus Cycle Sequencer

This block runs one external memory or peripheral access as a fixed series of six timed phases, A through F. Each phase has a length set by a per-region timing word. A function word supplies the rest of the access configuration: whether the chip select may be used, whether a READY handshake stretches the access, how READY is sampled, and the bus type. The bus type is 8 or 16 bits wide, with address and data either sharing the AD pins or on separate pins.

A requester offers an address, a write flag and write data while the sequencer is idle. The sequencer then takes the configuration and request in that cycle and keeps them until the access ends. Through the access it drives an active-low chip select, the address pins, the AD bus with its output enable, an address latch enable and the two strobes. After the last phase with a nonzero length it gives a one-cycle completion pulse. For reads, the captured data is held on a port until the next read.

Top module: `ext_bus_sequencer`

## Requirements
- R1: After reset the chip select, read strobe and write strobe are high (inactive). The latch enable, AD output enable, completion pulse, refusal pulse and busy flag are low.
- R2: An accepted access holds the chip select low for A + (B+1) + C + D + (E+1) + F cycles, where A, B, C, D, E, read-F and write-F are read from timing word bits [1:0], [2], [4:3], [5], [10:6], [12:11] and [14:13]. It starts in the cycle after the clock edge that accepts the request.
- R3: A phase whose length is zero takes no cycle. With an all-zero timing word the access lasts exactly 2 cycles.
- R4: Phase F uses the write-F field for writes and the read-F field for reads.
- R5: When function bit 4 is set (multiplexed bus, type codes 1 and 3), the latch enable is high for exactly the A cycles. During those cycles AD carries the low address bits. When bit 4 is clear, the latch enable stays low.
- R6: On a write, the sequencer drives the write data onto AD with the output enable high from phase C through phase F. On a read, the output enable is high only during a multiplexed phase A.
- R7: When function bit 5 is clear (8-bit bus, type codes 0 and 1), the upper byte of AD and of the returned read data is zero.
- R8: The strobe matching the direction (read strobe for reads, write strobe for writes) is low exactly during phase E. The other strobe stays high, and the two are never low together.
- R9: When function bit 1 (READY enable) is clear, the READY input has no effect on the access.
- R10: When READY is enabled with function bit 2 set (synchronous mode), phase E ends at the first clock edge where its count has run out and READY is high.
- R11: When READY is enabled with function bit 2 clear (asynchronous mode), READY passes through a two-flop synchronizer. Phase E therefore ends two cycles later than it would in synchronous mode.
- R12: A request made while function bit 0 (chip-select enable) is clear is refused. A one-cycle refusal pulse appears in the next cycle and the chip select stays high.
- R13: The completion pulse is high for one cycle, in the cycle right after the chip select returns high. For reads, the read data port then holds the AD value sampled at the end of phase E.
- R14: A request raised while an access is in progress is ignored. The address pins and the access length stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Access request, sampled while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | 16 | Write data |
| timing_word | input | 15 | Phase lengths of the target region |
| func_word | input | 6 | Enable, READY control and bus type of the target region |
| ready_in | input | 1 | External READY |
| ad_in | input | 16 | AD bus value read from the pins |
| busy | output | 1 | An access is in progress |
| reject | output | 1 | One-cycle refusal pulse |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Last read data |
| cs_n | output | 1 | Chip select, active low |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| addr_out | output | AW | Address pins |
| ad_out | output | 16 | AD bus drive value |
| ad_oe | output | 1 | AD bus output enable |

## Verification
A wrong phase register or a skipped counter reload shows up in the chip-select width, so the bench counts every low cycle of the chip select and compares it with the sum of the fields. A corrupted latched configuration shows in the latch-enable count, the strobe count or the output-enable count within the same access. A broken READY path shows as a strobe that is too short or too long. That difference is exactly zero or two cycles between the two READY modes. Read capture errors surface in the cycle after the completion pulse.

// File: rtl/xbs_pkg.sv
package xbs_pkg;

    localparam int DW     = 16;
    localparam int TW_W   = 15;
    localparam int FW_W   = 6;
    localparam int CNT_W  = 5;
    localparam int LEN_W  = CNT_W + 1;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_A    = 3'd1,
        PH_B    = 3'd2,
        PH_C    = 3'd3,
        PH_D    = 3'd4,
        PH_E    = 3'd5,
        PH_F    = 3'd6
    } phase_e;

    // Packed from MSB down: matches the timing word bit positions.
    typedef struct packed {
        logic [1:0] f_wr;
        logic [1:0] f_rd;
        logic [4:0] e;
        logic       d;
        logic [1:0] c;
        logic       b;
        logic [1:0] a;
    } timing_t;

    typedef struct packed {
        logic wide;      // 16-bit bus
        logic mux;       // address and data share AD
        logic rdy_sync;  // READY sampled directly
        logic rdy_en;    // READY stretches phase E
        logic cs_en;     // chip select usable
    } func_t;

    function automatic func_t decode_func(logic [FW_W-1:0] w);
        func_t f;
        f.wide     = w[5];
        f.mux      = w[4];
        f.rdy_sync = w[2];
        f.rdy_en   = w[1];
        f.cs_en    = w[0];
        return f;
    endfunction

    function automatic logic [LEN_W-1:0] phase_len(phase_e ph, timing_t t, logic wr);
        case (ph)
            PH_A:    return LEN_W'(t.a);
            PH_B:    return LEN_W'(t.b) + LEN_W'(1);
            PH_C:    return LEN_W'(t.c);
            PH_D:    return LEN_W'(t.d);
            PH_E:    return LEN_W'(t.e) + LEN_W'(1);
            PH_F:    return wr ? LEN_W'(t.f_wr) : LEN_W'(t.f_rd);
            default: return '0;
        endcase
    endfunction

    // First phase after cur with a nonzero length, or idle when none is left.
    function automatic phase_e next_phase(phase_e cur, timing_t t, logic wr);
        phase_e res;
        res = PH_IDLE;
        for (int i = 6; i >= 1; i--) begin
            if (i > int'(cur) && phase_len(phase_e'(3'(i)), t, wr) != '0)
                res = phase_e'(3'(i));
        end
        return res;
    endfunction

    function automatic logic [DW-1:0] lane_mask(logic [DW-1:0] v, logic wide);
        return wide ? v : {8'h00, v[7:0]};
    endfunction

endpackage

// File: rtl/xbs_ready_sync.sv
module xbs_ready_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ready_in,
    input  logic sync_mode,
    output logic rdy_seen
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= ready_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= 1'b0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign rdy_seen = sync_mode ? ready_in : chain[STAGES-1];

    // R11
    sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(chain[STAGES-1]) |-> $past(chain[0]));

endmodule

// File: rtl/xbs_phase_ctrl.sv
module xbs_phase_ctrl
    import xbs_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [AW-1:0]       req_addr,
    input  logic [DW-1:0]       req_wdata,
    input  timing_t             tw_in,
    input  func_t               fw_in,
    input  logic                rdy_seen,
    input  logic [DW-1:0]       ad_in,
    output phase_e              phase,
    output func_t               cfg_f,
    output logic                wr_q,
    output logic [AW-1:0]       addr_q,
    output logic [DW-1:0]       wdata_q,
    output logic [DW-1:0]       rdata,
    output logic                done,
    output logic                reject
);
    timing_t          cfg_t;
    logic [CNT_W-1:0] cnt;

    phase_e           start_ph;
    phase_e           run_nxt;
    logic [LEN_W-1:0] start_len;
    logic [LEN_W-1:0] run_len;
    logic             phase_end;

    always_comb begin
        start_ph  = next_phase(PH_IDLE, tw_in, req_write);
        start_len = phase_len(start_ph, tw_in, req_write);
        run_nxt   = next_phase(phase, cfg_t, wr_q);
        run_len   = phase_len(run_nxt, cfg_t, wr_q);
        phase_end = (cnt == '0) &&
                    (phase != PH_E || !cfg_f.rdy_en || rdy_seen);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            cfg_t   <= '0;
            cfg_f   <= '0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata   <= '0;
            done    <= 1'b0;
            reject  <= 1'b0;
        end else begin
            done   <= 1'b0;
            reject <= 1'b0;
            if (phase == PH_IDLE) begin
                if (req_valid) begin
                    if (!fw_in.cs_en) begin
                        reject <= 1'b1;
                    end else begin
                        cfg_t   <= tw_in;
                        cfg_f   <= fw_in;
                        wr_q    <= req_write;
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        phase   <= start_ph;
                        cnt     <= CNT_W'(start_len - LEN_W'(1));
                    end
                end
            end else if (cnt != '0) begin
                cnt <= cnt - CNT_W'(1);
            end else if (phase_end) begin
                if (phase == PH_E && !wr_q)
                    rdata <= lane_mask(ad_in, cfg_f.wide);
                phase <= run_nxt;
                if (run_nxt == PH_IDLE) done <= 1'b1;
                else cnt <= CNT_W'(run_len - LEN_W'(1));
            end
        end
    end

    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R12
    reject_idle_chk: assert property (@(posedge clk) disable iff (rst)
        reject |-> (phase == PH_IDLE && !done));

    // R2
    phase_order_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != $past(phase) && $past(phase) != PH_IDLE)
            |-> (phase == PH_IDLE || phase > $past(phase)));

    // R14
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> $stable(addr_q));

    // R13
    done_after_access_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (phase == PH_IDLE && $past(phase) != PH_IDLE));

endmodule

// File: rtl/xbs_pin_drive.sv
module xbs_pin_drive
    import xbs_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  phase_e              phase,
    input  func_t               cfg_f,
    input  logic                wr_q,
    input  logic [AW-1:0]       addr_q,
    input  logic [DW-1:0]       wdata_q,
    output logic                cs_n,
    output logic                ale,
    output logic                rd_n,
    output logic                wr_n,
    output logic [AW-1:0]       addr_out,
    output logic [DW-1:0]       ad_out,
    output logic                ad_oe
);
    logic active;
    logic data_ph;
    logic addr_ph;

    always_comb begin
        active   = (phase != PH_IDLE);
        data_ph  = phase inside {PH_C, PH_D, PH_E, PH_F};
        addr_ph  = cfg_f.mux && (phase == PH_A);
        cs_n     = !active;
        ale      = addr_ph;
        addr_out = active ? addr_q : '0;
        rd_n     = !(phase == PH_E && !wr_q);
        wr_n     = !(phase == PH_E && wr_q);
        if (addr_ph) begin
            ad_oe  = 1'b1;
            ad_out = lane_mask(addr_q[DW-1:0], cfg_f.wide);
        end else if (wr_q && data_ph) begin
            ad_oe  = 1'b1;
            ad_out = lane_mask(wdata_q, cfg_f.wide);
        end else begin
            ad_oe  = 1'b0;
            ad_out = '0;
        end
    end

    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    // R5
    ale_drives_chk: assert property (@(posedge clk) disable iff (rst)
        ale |-> (ad_oe && !cs_n));

    // R8
    strobe_in_cs_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |-> !cs_n);

endmodule

// File: rtl/ext_bus_sequencer.sv
module ext_bus_sequencer
    import xbs_pkg::*;
#(
    parameter int AW          = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [AW-1:0]   req_addr,
    input  logic [15:0]     req_wdata,
    input  logic [14:0]     timing_word,
    input  logic [5:0]      func_word,
    input  logic            ready_in,
    input  logic [15:0]     ad_in,
    output logic            busy,
    output logic            reject,
    output logic            done,
    output logic [15:0]     rdata,
    output logic            cs_n,
    output logic            ale,
    output logic            rd_n,
    output logic            wr_n,
    output logic [AW-1:0]   addr_out,
    output logic [15:0]     ad_out,
    output logic            ad_oe
);
    phase_e        phase;
    func_t         cfg_f;
    logic          wr_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic          rdy_seen;
    logic          unused_fw3;

    assign unused_fw3 = func_word[3];
    assign busy       = (phase != PH_IDLE);

    xbs_ready_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .ready_in  (ready_in),
        .sync_mode (cfg_f.rdy_sync),
        .rdy_seen  (rdy_seen)
    );

    xbs_phase_ctrl #(.AW(AW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .tw_in     (timing_t'(timing_word)),
        .fw_in     (decode_func(func_word)),
        .rdy_seen  (rdy_seen),
        .ad_in     (ad_in),
        .phase     (phase),
        .cfg_f     (cfg_f),
        .wr_q      (wr_q),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .rdata     (rdata),
        .done      (done),
        .reject    (reject)
    );

    xbs_pin_drive #(.AW(AW)) u_pins (
        .clk      (clk),
        .rst      (rst),
        .phase    (phase),
        .cfg_f    (cfg_f),
        .wr_q     (wr_q),
        .addr_q   (addr_q),
        .wdata_q  (wdata_q),
        .cs_n     (cs_n),
        .ale      (ale),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .addr_out (addr_out),
        .ad_out   (ad_out),
        .ad_oe    (ad_oe)
    );

endmodule

// File: tb/ext_bus_sequencer_test.sv
`timescale 1ns/1ps
module ext_bus_sequencer_test;
    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_wdata = '0;
    logic [14:0]   timing_word = '0;
    logic [5:0]    func_word = '0;
    logic          ready_in = 1'b1;
    logic [15:0]   ad_in = '0;
    logic          busy, reject, done, cs_n, ale, rd_n, wr_n, ad_oe;
    logic [15:0]   rdata, ad_out;
    logic [AW-1:0] addr_out;

    int checks = 0;
    int fails  = 0;

    ext_bus_sequencer #(.AW(AW)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .timing_word(timing_word),
        .func_word(func_word), .ready_in(ready_in), .ad_in(ad_in),
        .busy(busy), .reject(reject), .done(done), .rdata(rdata),
        .cs_n(cs_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .addr_out(addr_out), .ad_out(ad_out), .ad_oe(ad_oe)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [14:0] mk_tw(int a, int b, int c, int d, int e, int fr, int fw);
        return {2'(fw), 2'(fr), 5'(e), 1'(d), 2'(c), 1'(b), 2'(a)};
    endfunction

    // wait_len: for READY-enabled runs, strobe cycles before READY is raised
    task automatic run_access(input logic [14:0] tw, input logic [5:0] fw, input bit wr,
                              input logic [AW-1:0] addr, input logic [15:0] wd,
                              input logic [15:0] rin, input int wait_len, input bit poke);
        int a  = int'(tw[1:0]);
        int b  = int'(tw[2]) + 1;
        int c  = int'(tw[4:3]);
        int d  = int'(tw[5]);
        int e  = int'(tw[10:6]) + 1;
        int f  = wr ? int'(tw[14:13]) : int'(tw[12:11]);
        bit wide = fw[5];
        bit mux  = fw[4];
        bit ren  = fw[1];
        bit rsyn = fw[2];
        int exp_st = ren ? (rsyn ? wait_len : wait_len + 2) : e;
        int exp_tot = a + b + c + d + exp_st + f;
        int exp_ale = mux ? a : 0;
        int exp_oe  = exp_ale + (wr ? c + d + exp_st + f : 0);
        logic [15:0] exp_ad = wide ? addr[15:0] : {8'h00, addr[7:0]};
        logic [15:0] exp_wd = wide ? wd : {8'h00, wd[7:0]};
        logic [15:0] exp_rd = wide ? rin : {8'h00, rin[7:0]};
        int cyc = 0, ale_c = 0, oe_c = 0, st_c = 0;
        int bad_addr = 0, bad_mux = 0, bad_wd = 0, bad_st = 0;
        bit fin = 0;
        timing_word = tw; func_word = fw; ad_in = rin;
        ready_in = ren ? 1'b0 : 1'b1;
        repeat (3) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 400 && !fin; k++) begin
            if (!cs_n) begin
                cyc++;
                if (ale) ale_c++;
                if (ad_oe) oe_c++;
                if (addr_out != addr) bad_addr++;
                if (ale && ad_out != exp_ad) bad_mux++;
                if (wr ? !rd_n : !wr_n) bad_st++;
                if (wr ? !wr_n : !rd_n) begin
                    st_c++;
                    if (wr && (!ad_oe || ad_out != exp_wd)) bad_wd++;
                    if (ren && st_c == wait_len) ready_in = 1'b1;
                end
                if (!ren) ready_in = 1'($urandom % 2);
                if (poke && cyc == 2) begin
                    req_valid = 1'b1; req_addr = ~addr;
                end else if (poke && cyc == 3) begin
                    req_valid = 1'b0; req_addr = addr;
                end
                @(negedge clk);
            end else begin
                fin = 1;
            end
        end
        chk(fin, "R2 access ended", int'(fin), 1);
        chk(cyc == exp_tot, ren ? (rsyn ? "R10 length" : "R11 length") : "R2 R3 R4 R9 length",
            cyc, exp_tot);
        chk(ale_c == exp_ale, "R5 ale cycles", ale_c, exp_ale);
        chk(bad_mux == 0, "R5 R7 address on AD", bad_mux, 0);
        chk(oe_c == exp_oe, "R6 output enable cycles", oe_c, exp_oe);
        chk(st_c == exp_st, "R8 strobe cycles", st_c, exp_st);
        chk(bad_st == 0, "R8 wrong strobe", bad_st, 0);
        chk(bad_wd == 0, "R6 R7 write data", bad_wd, 0);
        chk(bad_addr == 0, "R14 address pins", bad_addr, 0);
        chk(done == 1'b1, "R13 done after access", int'(done), 1);
        if (!wr) chk(rdata == exp_rd, "R13 R7 read data", int'(rdata), int'(exp_rd));
        @(negedge clk);
        chk(done == 1'b0 && cs_n == 1'b1, "R13 done one cycle", int'(done), 0);
    endtask

    initial begin
        int cyc_guard = 0;
        forever begin
            @(posedge clk);
            cyc_guard++;
            if (cyc_guard > 150000) begin
                chk(0, "watchdog", cyc_guard, 150000);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(cs_n && rd_n && wr_n, "R1 strobes idle", int'({cs_n, rd_n, wr_n}), 7);
        chk(!ale && !ad_oe && !done && !reject && !busy, "R1 outputs low",
            int'({ale, ad_oe, done, reject, busy}), 0);

        // R3 minimal access, 16-bit demultiplexed read
        run_access(mk_tw(0,0,0,0,0,0,0), 6'b100001, 1'b0, 24'h123456, 16'h0, 16'hBEEF, 0, 0);
        // R2 R5 longest access, 16-bit multiplexed write
        run_access(15'h7FFF, 6'b110001, 1'b1, 24'hABCDEF, 16'h5AA5, 16'h0, 0, 0);
        // R4 separate recovery lengths
        run_access(mk_tw(1,0,1,0,2,1,3), 6'b100001, 1'b0, 24'h000100, 16'h0, 16'h1234, 0, 0);
        run_access(mk_tw(1,0,1,0,2,1,3), 6'b100001, 1'b1, 24'h000100, 16'hC3C3, 16'h0, 0, 0);
        // R7 8-bit multiplexed read and 8-bit demultiplexed write
        run_access(mk_tw(2,1,0,1,3,2,0), 6'b010001, 1'b0, 24'h00A5F0, 16'h0, 16'hFE81, 0, 0);
        run_access(mk_tw(0,0,2,0,1,0,1), 6'b000001, 1'b1, 24'h0077CC, 16'h9966, 16'h0, 0, 0);
        // R10 synchronous READY, R11 asynchronous READY
        run_access(mk_tw(1,0,0,0,2,0,0), 6'b100111, 1'b0, 24'h00F00F, 16'h0, 16'h4321, 6, 0);
        run_access(mk_tw(1,0,0,0,2,0,0), 6'b100011, 1'b0, 24'h00F00F, 16'h0, 16'h8765, 6, 0);
        run_access(mk_tw(0,1,1,0,3,0,2), 6'b110111, 1'b1, 24'h010203, 16'h7E7E, 16'h0, 4, 0);
        // R14 request during an access
        run_access(mk_tw(1,1,1,1,4,1,1), 6'b100001, 1'b0, 24'h0F0F0F, 16'h0, 16'h2468, 0, 1);

        // R12 refused request
        @(negedge clk);
        func_word = 6'b100000; timing_word = '0;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 24'h111111;
        @(negedge clk);
        req_valid = 1'b0;
        chk(reject == 1'b1, "R12 refusal pulse", int'(reject), 1);
        chk(cs_n == 1'b1 && !busy, "R12 no chip select", int'(cs_n), 1);
        @(negedge clk);
        chk(reject == 1'b0 && cs_n == 1'b1, "R12 refusal one cycle", int'(reject), 0);

        // random accesses (R2 R4 R5 R6 R7 R8 R9 R10 R11)
        for (int n = 0; n < 40; n++) begin
            logic [14:0] tw = 15'($urandom);
            logic [5:0]  fw = {2'($urandom), 1'b0, 2'($urandom), 1'b1};
            int wl = int'(tw[10:6]) + 1 + int'($urandom % 4);
            run_access(tw, fw, 1'($urandom), 24'($urandom), 16'($urandom),
                       16'($urandom), wl, 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule